// File: doc/BRIEF.md
# Ramped Six-Channel Mute Attenuator

This block drives the current attenuation code of six audio output channels. Each channel moves toward a target in single half-decibel steps. While its mute bit is set, the target is full attenuation (code 181, 90.5 dB). While the bit is clear, the target is that channel's own stored volume code. Steps are not taken on every clock. A shared prescaler counts frame ticks, one per sample frame, and every channel moves one code on each prescaler wrap. As a result, muting and unmuting fade smoothly instead of switching at once.

The block takes three inputs: a control image holding the six mute bits and a two-bit rate code, the six stored volume codes, and the frame tick. A downstream stage turns the attenuation codes into gains. When a target changes in the middle of a ramp, the channel continues from its present code. It never jumps.

Top module: `mute_ramp_atten`

## Requirements
- R1: After reset every channel outputs code 181, the prescaler count is zero and the active rate code is 0.
- R2: Control bit 2+k is the mute bit of channel k+1 (k = 0..5), so bit 7 mutes channel 6. Bits 1:0 hold the rate code.
- R3: A channel whose mute bit is 1 has target code 181, and its code never decreases on a step.
- R4: A channel whose mute bit is 0 has as its target its 8-bit volume input, with any value above 181 treated as 181.
- R5: Each step changes a code by exactly one toward its target. A code already at its target holds, and the code always stays within 0..181.
- R6: A step occurs on every 4th, 8th, 16th or 32nd frame tick for rate code 0, 1, 2 or 3. Clock cycles without a tick do not advance the count.
- R7: A new rate code is taken up only at a prescaler wrap. The interval that is already running finishes at the old rate.
- R8: When the mute bit or the volume changes mid-ramp, the channel continues from its present code toward the new target.
- R9: The code changes on the clock edge that samples the frame tick that completes an interval, and at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per sample frame |
| ctrl_img | input | 8 | Mute bits [7:2] for channels 6..1, rate code [1:0] |
| vol_bus | input | 48 | Stored volume code of channel k+1 at bits [8k+7:8k] |
| att_bus | output | 48 | Current attenuation code of channel k+1 at bits [8k+7:8k] |

## Verification
A corrupted prescaler count or a stale latched rate code moves the step instants. This shows up as a channel code that is off by one or more codes within one 32-tick interval after the fault. A wrong channel register or a wrong target choice shows at that channel's output lane on the next step event. It appears either as a jump larger than one code, as a move away from the target, or as a code that passes 181 or wraps below zero. The bench follows the codes through rate changes that fall mid-interval, through idle cycles without ticks, and across full ramps to both ends of the range.

// File: rtl/mr_pkg.sv
package mr_pkg;

  localparam int unsigned DEF_NCH       = 6;
  localparam int unsigned DEF_ATT_W     = 8;
  localparam int unsigned DEF_MAX_ATT   = 181;
  localparam int unsigned DEF_RATE_W    = 2;
  localparam int unsigned DEF_BASE_LOG2 = 2;

  // Limit a requested volume code to the full-attenuation code.
  function automatic int unsigned clamp_code(input int unsigned v, input int unsigned mx);
    return (v > mx) ? mx : v;
  endfunction

  // One code toward the target, or stay when already there.
  function automatic int unsigned step_toward(input int unsigned cur, input int unsigned tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/mr_prescaler.sv
module mr_prescaler #(
  parameter int unsigned RATE_W    = mr_pkg::DEF_RATE_W,
  parameter int unsigned BASE_LOG2 = mr_pkg::DEF_BASE_LOG2,
  localparam int unsigned PRE_W    = BASE_LOG2 + (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o
);

  logic [PRE_W-1:0]  cnt_q;
  logic [RATE_W-1:0] rate_q;
  logic [PRE_W-1:0]  last_w;
  logic              wrap_w;

  // Final count of an interval: 2^(BASE_LOG2 + rate) - 1.
  function automatic logic [PRE_W-1:0] last_of(input logic [RATE_W-1:0] r);
    return PRE_W'((32'd1 << (BASE_LOG2 + 32'(r))) - 32'd1);
  endfunction

  assign last_w = last_of(rate_q);
  assign wrap_w = tick_i && (cnt_q == last_w);
  assign step_o = wrap_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else if (tick_i) begin
      if (wrap_w) begin
        cnt_q  <= '0;
        rate_q <= rate_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_of(rate_q)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R6
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> (cnt_q == '0)); // R6
  AST_RATE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_w |=> $stable(rate_q)); // R7

endmodule

// File: rtl/mr_channel.sv
module mr_channel #(
  parameter int unsigned ATT_W   = mr_pkg::DEF_ATT_W,
  parameter int unsigned MAX_ATT = mr_pkg::DEF_MAX_ATT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             mute_i,
  input  logic [ATT_W-1:0] vol_i,
  output logic [ATT_W-1:0] att_o
);

  localparam logic [ATT_W-1:0] MAX_CODE = ATT_W'(MAX_ATT);
  localparam logic [ATT_W-1:0] ONE      = ATT_W'(1);

  logic [ATT_W-1:0] att_q;
  logic [ATT_W-1:0] target_w;
  logic [ATT_W-1:0] next_w;

  assign target_w = mute_i ? MAX_CODE
                           : ATT_W'(mr_pkg::clamp_code(32'(vol_i), MAX_ATT));
  assign next_w   = ATT_W'(mr_pkg::step_toward(32'(att_q), 32'(target_w)));
  assign att_o    = att_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      att_q <= MAX_CODE;
    else if (step_i) att_q <= next_w;
  end

  AST_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (att_q == $past(att_q)) || (att_q == $past(att_q) + ONE)
               || (att_q == $past(att_q) - ONE)); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= MAX_CODE); // R5
  AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (att_q == target_w)) |=> $stable(att_q)); // R5
  AST_MUTE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mute_i) |=> (att_q >= $past(att_q))); // R3
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(att_q)); // R9

endmodule

// File: rtl/mute_ramp_atten.sv
module mute_ramp_atten #(
  parameter int unsigned NCH       = mr_pkg::DEF_NCH,
  parameter int unsigned ATT_W     = mr_pkg::DEF_ATT_W,
  parameter int unsigned MAX_ATT   = mr_pkg::DEF_MAX_ATT,
  parameter int unsigned RATE_W    = mr_pkg::DEF_RATE_W,
  parameter int unsigned BASE_LOG2 = mr_pkg::DEF_BASE_LOG2,
  localparam int unsigned CTRL_W   = NCH + RATE_W,
  localparam int unsigned BUS_W    = NCH * ATT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [CTRL_W-1:0] ctrl_img,
  input  logic [BUS_W-1:0]  vol_bus,
  output logic [BUS_W-1:0]  att_bus
);

  logic step_evt;

  mr_prescaler #(
    .RATE_W    (RATE_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (frame_tick),
    .rate_i (ctrl_img[RATE_W-1:0]),
    .step_o (step_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mr_channel #(
      .ATT_W   (ATT_W),
      .MAX_ATT (MAX_ATT)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_evt),
      .mute_i (ctrl_img[RATE_W + g]),
      .vol_i  (vol_bus[g*ATT_W +: ATT_W]),
      .att_o  (att_bus[g*ATT_W +: ATT_W])
    );
  end

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> frame_tick); // R6

endmodule

// File: tb/mute_ramp_atten_tb.sv
module mute_ramp_atten_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [7:0]  ctrl_img = 8'hFC;
  logic [47:0] vol_bus = '0;
  logic [47:0] att_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mute_ramp_atten u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .ctrl_img   (ctrl_img),
    .vol_bus    (vol_bus),
    .att_bus    (att_bus)
  );

  // Row: ctrl, vol ch1..5, vol ch6, ticks, expected ch1, expected ch6
  localparam logic [47:0] VEC [10] = '{
    {8'hF8, 8'd170, 8'd10,  8'd8,  8'd179, 8'd181},
    {8'h78, 8'd170, 8'd178, 8'd12, 8'd176, 8'd178},
    {8'h78, 8'd200, 8'd178, 8'd8,  8'd178, 8'd178},
    {8'h79, 8'd170, 8'd178, 8'd4,  8'd177, 8'd178},
    {8'h79, 8'd170, 8'd178, 8'd7,  8'd177, 8'd178},
    {8'h79, 8'd170, 8'd178, 8'd1,  8'd176, 8'd178},
    {8'h7D, 8'd170, 8'd178, 8'd16, 8'd178, 8'd178},
    {8'h7F, 8'd170, 8'd178, 8'd8,  8'd179, 8'd178},
    {8'h7F, 8'd170, 8'd178, 8'd31, 8'd179, 8'd178},
    {8'h7F, 8'd170, 8'd178, 8'd1,  8'd180, 8'd178}
  };

  function automatic int lane(input int k);
    return int'(att_bus[k*8 +: 8]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_vols(input logic [7:0] v15, input logic [7:0] v6);
    for (int k = 0; k < 5; k++) vol_bus[k*8 +: 8] = v15;
    vol_bus[40 +: 8] = v6;
  endtask

  // One frame tick per two clocks; ends at a negedge after the sampling edge.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < NCH; k++) check("R1 reset code", lane(k), 181);
    rst_n = 1'b1;

    // Table walk: R2 bit mapping, R3/R4 targets, R6/R7 rate timing, R8 retarget
    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      ctrl_img = VEC[r][47:40];
      set_vols(VEC[r][39:32], VEC[r][31:24]);
      ticks(int'(VEC[r][23:16]));
      check($sformatf("R6/R7/R8 row %0d ch1", r), lane(0), int'(VEC[r][15:8]));
      check($sformatf("R2/R4 row %0d ch6", r), lane(5), int'(VEC[r][7:0]));
      for (int k = 1; k < 5; k++)
        check($sformatf("R3 row %0d muted ch%0d", r, k+1), lane(k), 181);
    end

    // R6: clocks without ticks do not count; R9: no change without a step
    @(negedge clk);
    ctrl_img = 8'h7B;
    set_vols(8'd100, 8'd178);
    repeat (60) @(negedge clk);
    check("R6 idle clocks ch1", lane(0), 180);
    ticks(31);
    check("R9 before interval end ch1", lane(0), 180);
    ticks(1);
    check("R8 unmute reverses ch1", lane(0), 179);

    // R1: reset clears a part-filled count and the latched rate
    ticks(5);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NCH; k++) check("R1 code after mid reset", lane(k), 181);
    ctrl_img = 8'h00;
    set_vols(8'd0, 8'd0);
    rst_n = 1'b1;
    ticks(3);
    check("R1 rate 0 no early step", lane(0), 181);
    ticks(1);
    for (int k = 0; k < NCH; k++) check("R1 rate 0 after reset", lane(k), 180);

    // R5: full ramp down to 0, one code per 4 ticks, and hold at 0
    for (int c = 179; c >= 0; c--) begin
      ticks(4);
      check("R5 ramp down ch1", lane(0), c);
    end
    ticks(8);
    for (int k = 0; k < NCH; k++) check("R5 hold at floor", lane(k), 0);

    // R4/R5: volume 255 clamps to 181, ramp up stops there
    @(negedge clk);
    set_vols(8'd255, 8'd255);
    ticks(4 * 181);
    check("R4 clamp reached ch1", lane(0), 181);
    ticks(8);
    for (int k = 0; k < NCH; k++) check("R5 hold at clamp", lane(k), 181);

    done = 1'b1;
    finish_run();
  end

endmodule